// File: doc/BRIEF.md
# Relocation and Limit Protection Unit

This unit sits between a processor's address generator and memory. It turns each user-mode logical address into a physical address. A logical address is a segment number paired with an offset. The segment number picks one entry from a small table of relocation/limit pairs. The offset is compared with that entry's limit. If the offset is below the limit, the entry's relocation value is added to it. Anything else ends in a protection fault, and no memory access is issued for it.

Kernel-mode requests are neither checked nor translated. The segment and offset bits are joined and passed on as a flat physical address, which gives the kernel reach over all of memory. The table can be loaded only through a write port, and only when the writer is in kernel mode. A write from user mode is dropped. After reset every limit is zero, so every user access faults until kernel code has loaded the table. Results are registered and appear one clock after the request.

Top module: `reloc_guard`

## Requirements
- R1: After reset `rsp_valid` and `rsp_fault` are 0, and every table limit is zero, so a user request to any segment gives `rsp_fault`=1 in the following cycle.
- R2: A user request (`req_kernel`=0) with `req_ofs` below the limit of segment `req_seg` gives `rsp_valid`=1, `rsp_fault`=0 and `rsp_addr` = (relocation + `req_ofs`) modulo 2^PHYS_W in the following cycle.
- R3: A user request with `req_ofs` equal to or above the segment's limit gives `rsp_fault`=1 and `rsp_valid`=0 in the following cycle. An offset of limit-1 is legal and an offset equal to the limit faults.
- R4: A user request whose `req_seg` is NUM_SEGS or greater (segment 3 with the defaults) faults in the same way as a limit violation.
- R5: A kernel request (`req_kernel`=1) gives `rsp_valid`=1 and `rsp_fault`=0 in the following cycle, with `rsp_addr` = {`req_seg`,`req_ofs`} zero-extended, whatever the table holds.
- R6: A write with `cfg_we`=1 and `cfg_kernel`=1 loads `cfg_data` into segment `cfg_seg`. `cfg_field`=0 selects the relocation value. `cfg_field`=1 selects the limit, which takes the low OFS_W+1 bits. The new value governs requests from the next cycle on. A write to a segment of NUM_SEGS or above changes nothing.
- R7: A write with `cfg_we`=1 and `cfg_kernel`=0 is rejected and leaves the table unchanged.
- R8: A request presented in the same cycle as a write to its own segment is judged against the table contents from before that write.
- R9: A cycle with `req_valid`=0 gives `rsp_valid`=0 and `rsp_fault`=0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_kernel | input | 1 | Writer is in kernel mode |
| cfg_seg | input | SEG_W | Segment entry to write |
| cfg_field | input | 1 | 0 = relocation value, 1 = limit |
| cfg_data | input | PHYS_W | Value to load |
| req_valid | input | 1 | Address request present |
| req_kernel | input | 1 | Requester is in kernel mode |
| req_seg | input | SEG_W | Segment number of the logical address |
| req_ofs | input | OFS_W | Offset within the segment |
| rsp_valid | output | 1 | Memory access issued with `rsp_addr` |
| rsp_addr | output | PHYS_W | Physical address |
| rsp_fault | output | 1 | Protection fault for the previous request |

## Verification
The table write and the address check can act on the same segment in the same cycle. The bench provokes this by raising a kernel write to segment 0's limit in the cycle where a user request falls between the old and the new limit. The request must fault, because it is judged against the old limit. The same request sent one cycle later must translate, because the new limit is then in force.

// File: rtl/reloc_pkg.sv
package reloc_pkg;
   typedef enum logic {
      FIELD_BASE  = 1'b0,
      FIELD_LIMIT = 1'b1
   } field_e;
endpackage

// File: rtl/reloc_table.sv
module reloc_table
   import reloc_pkg::*;
#(
   parameter int SEG_W    = 2,
   parameter int NUM_SEGS = 3,
   parameter int PHYS_W   = 20,
   parameter int LIM_W    = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEG_W-1:0]  wr_seg,
   input  field_e            wr_field,
   input  logic [PHYS_W-1:0] wr_data,
   input  logic [SEG_W-1:0]  rd_seg,
   output logic [PHYS_W-1:0] rd_base,
   output logic [LIM_W-1:0]  rd_limit,
   output logic              rd_present
);
   logic [PHYS_W-1:0] base_a  [NUM_SEGS];
   logic [LIM_W-1:0]  limit_a [NUM_SEGS];

   for (genvar i = 0; i < NUM_SEGS; i++) begin : g_ent
      logic [PHYS_W-1:0] base_r;
      logic [LIM_W-1:0]  limit_r;
      logic              hit;
      assign hit = wr_en && (wr_seg == SEG_W'(i));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            base_r  <= '0;
            limit_r <= '0;
         end else if (hit) begin
            if (wr_field == FIELD_BASE) base_r  <= wr_data;
            else                        limit_r <= wr_data[LIM_W-1:0];
         end
      end
      assign base_a[i]  = base_r;
      assign limit_a[i] = limit_r;
   end

   if (NUM_SEGS == (1 << SEG_W)) begin : g_full
      assign rd_present = 1'b1;
   end else begin : g_part
      assign rd_present = (int'(rd_seg) < NUM_SEGS);
   end

   always_comb begin
      rd_base  = '0;
      rd_limit = '0;
      for (int i = 0; i < NUM_SEGS; i++) begin
         if (rd_seg == SEG_W'(i)) begin
            rd_base  = base_a[i];
            rd_limit = limit_a[i];
         end
      end
   end
endmodule

// File: rtl/reloc_check.sv
module reloc_check #(
   parameter int SEG_W  = 2,
   parameter int OFS_W  = 16,
   parameter int PHYS_W = 20,
   parameter int LIM_W  = 17
) (
   input  logic              kernel,
   input  logic [SEG_W-1:0]  seg,
   input  logic [OFS_W-1:0]  ofs,
   input  logic [PHYS_W-1:0] base,
   input  logic [LIM_W-1:0]  limit,
   input  logic              present,
   output logic [PHYS_W-1:0] phys,
   output logic              fault
);
   logic in_range;
   assign in_range = ({1'b0, ofs} < limit);
   assign fault    = !kernel && !(present && in_range);
   assign phys     = kernel ? PHYS_W'({seg, ofs}) : (base + PHYS_W'(ofs));
endmodule

// File: rtl/reloc_guard.sv
module reloc_guard
   import reloc_pkg::*;
#(
   parameter int SEG_W    = 2,
   parameter int NUM_SEGS = 3,
   parameter int OFS_W    = 16,
   parameter int PHYS_W   = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_kernel,
   input  logic [SEG_W-1:0]  cfg_seg,
   input  logic              cfg_field,
   input  logic [PHYS_W-1:0] cfg_data,
   input  logic              req_valid,
   input  logic              req_kernel,
   input  logic [SEG_W-1:0]  req_seg,
   input  logic [OFS_W-1:0]  req_ofs,
   output logic              rsp_valid,
   output logic [PHYS_W-1:0] rsp_addr,
   output logic              rsp_fault
);
   localparam int LIM_W = OFS_W + 1;

   if (NUM_SEGS < 1 || NUM_SEGS > (1 << SEG_W)) begin : g_bad_segs
      $error("NUM_SEGS must lie in 1..2**SEG_W");
   end
   if (PHYS_W < SEG_W + OFS_W || PHYS_W < LIM_W) begin : g_bad_phys
      $error("PHYS_W too narrow for flat kernel addresses or limits");
   end

   logic [PHYS_W-1:0] t_base;
   logic [LIM_W-1:0]  t_limit;
   logic              t_present;
   logic [PHYS_W-1:0] c_phys;
   logic              c_fault;

   reloc_table #(
      .SEG_W(SEG_W), .NUM_SEGS(NUM_SEGS), .PHYS_W(PHYS_W), .LIM_W(LIM_W)
   ) u_table (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cfg_we && cfg_kernel),
      .wr_seg(cfg_seg),
      .wr_field(field_e'(cfg_field)),
      .wr_data(cfg_data),
      .rd_seg(req_seg),
      .rd_base(t_base), .rd_limit(t_limit), .rd_present(t_present)
   );

   reloc_check #(
      .SEG_W(SEG_W), .OFS_W(OFS_W), .PHYS_W(PHYS_W), .LIM_W(LIM_W)
   ) u_check (
      .kernel(req_kernel), .seg(req_seg), .ofs(req_ofs),
      .base(t_base), .limit(t_limit), .present(t_present),
      .phys(c_phys), .fault(c_fault)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_fault <= 1'b0;
         rsp_addr  <= '0;
      end else begin
         rsp_valid <= req_valid && !c_fault;
         rsp_fault <= req_valid && c_fault;
         rsp_addr  <= (req_valid && !c_fault) ? c_phys : '0;
      end
   end
endmodule

// File: rtl/reloc_guard_chk.sv
module reloc_guard_chk #(
   parameter int SEG_W    = 2,
   parameter int NUM_SEGS = 3,
   parameter int OFS_W    = 16,
   parameter int PHYS_W   = 20
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_kernel,
   input logic [SEG_W-1:0]  req_seg,
   input logic [OFS_W-1:0]  req_ofs,
   input logic              rsp_valid,
   input logic [PHYS_W-1:0] rsp_addr,
   input logic              rsp_fault
);
   // R3
   valid_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_valid && rsp_fault));

   // R9
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!rsp_valid && !rsp_fault));

   // R5
   kernel_flat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kernel) |=>
         (rsp_valid && !rsp_fault && rsp_addr == PHYS_W'({$past(req_seg), $past(req_ofs)})));

   // R4
   absent_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_kernel && int'(req_seg) >= NUM_SEGS) |=> (rsp_fault && !rsp_valid));

   // R2
   valid_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(req_valid));
endmodule

bind reloc_guard reloc_guard_chk #(
   .SEG_W(SEG_W), .NUM_SEGS(NUM_SEGS), .OFS_W(OFS_W), .PHYS_W(PHYS_W)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .req_valid(req_valid), .req_kernel(req_kernel),
   .req_seg(req_seg), .req_ofs(req_ofs),
   .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_fault(rsp_fault)
);

// File: tb/reloc_guard_bench.sv
module reloc_guard_bench;
   localparam int SEG_W = 2, NUM_SEGS = 3, OFS_W = 16, PHYS_W = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_we = 0, cfg_kernel = 0, cfg_field = 0;
   logic [SEG_W-1:0]  cfg_seg = '0;
   logic [PHYS_W-1:0] cfg_data = '0;
   logic req_valid = 0, req_kernel = 0;
   logic [SEG_W-1:0]  req_seg = '0;
   logic [OFS_W-1:0]  req_ofs = '0;
   logic rsp_valid, rsp_fault;
   logic [PHYS_W-1:0] rsp_addr;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   reloc_guard #(.SEG_W(SEG_W), .NUM_SEGS(NUM_SEGS), .OFS_W(OFS_W), .PHYS_W(PHYS_W))
   u_reloc_guard (.*);

   typedef struct packed {
      logic              kern;
      logic [SEG_W-1:0]  seg;
      logic [OFS_W-1:0]  ofs;
      logic              ev;
      logic              ef;
      logic [PHYS_W-1:0] ea;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 2'd0, 16'h0000, 1'b1, 1'b0, 20'h10000}, // R2 first word
      '{1'b0, 2'd0, 16'h00FF, 1'b1, 1'b0, 20'h100FF}, // R3 limit-1 legal
      '{1'b0, 2'd0, 16'h0100, 1'b0, 1'b1, 20'h00000}, // R3 offset == limit
      '{1'b0, 2'd1, 16'h0200, 1'b1, 1'b0, 20'h00100}, // R2 wraps
      '{1'b0, 2'd1, 16'h8000, 1'b0, 1'b1, 20'h00000}, // R3
      '{1'b0, 2'd2, 16'hFFFF, 1'b1, 1'b0, 20'h13FFF}, // R2 full range
      '{1'b0, 2'd3, 16'h0000, 1'b0, 1'b1, 20'h00000}, // R4
      '{1'b1, 2'd3, 16'h1234, 1'b1, 1'b0, 20'h31234}, // R5
      '{1'b1, 2'd0, 16'hFFFF, 1'b1, 1'b0, 20'h0FFFF}  // R5
   };

   task automatic check(input string tag, input logic ev, input logic ef,
                        input logic [PHYS_W-1:0] ea);
      n_chk++;
      if (rsp_valid !== ev || rsp_fault !== ef || (ev && rsp_addr !== ea)) begin
         n_bad++;
         $display("FAIL %s: valid=%0b fault=%0b addr=%h, expected valid=%0b fault=%0b addr=%h",
                  tag, rsp_valid, rsp_fault, rsp_addr, ev, ef, ea);
      end
   endtask

   // drives at a negedge, returns at the next negedge with the result visible
   task automatic issue(input logic k, input logic [SEG_W-1:0] s, input logic [OFS_W-1:0] o);
      req_valid = 1; req_kernel = k; req_seg = s; req_ofs = o;
      @(negedge clk);
      req_valid = 0;
   endtask

   task automatic write_cfg(input logic k, input logic [SEG_W-1:0] s, input logic f,
                            input logic [PHYS_W-1:0] d);
      cfg_we = 1; cfg_kernel = k; cfg_seg = s; cfg_field = f; cfg_data = d;
      @(negedge clk);
      cfg_we = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check("R1 reset outputs", 1'b0, 1'b0, '0);
      issue(1'b0, 2'd0, 16'h0000);
      check("R1 zero limit seg0", 1'b0, 1'b1, '0);
      issue(1'b0, 2'd2, 16'h0000);
      check("R1 zero limit seg2", 1'b0, 1'b1, '0);
      @(negedge clk);
      check("R9 idle", 1'b0, 1'b0, '0);

      // R6 kernel loads
      write_cfg(1'b1, 2'd0, 1'b0, 20'h10000);
      write_cfg(1'b1, 2'd0, 1'b1, 20'h00100);
      write_cfg(1'b1, 2'd1, 1'b0, 20'hFFF00);
      write_cfg(1'b1, 2'd1, 1'b1, 20'h08000);
      write_cfg(1'b1, 2'd2, 1'b0, 20'h04000);
      write_cfg(1'b1, 2'd2, 1'b1, 20'h10000);

      for (int i = 0; i < NV; i++) begin
         issue(VEC[i].kern, VEC[i].seg, VEC[i].ofs);
         check($sformatf("R2/R3/R4/R5 vector %0d", i), VEC[i].ev, VEC[i].ef, VEC[i].ea);
      end

      // R7 user write rejected
      write_cfg(1'b0, 2'd0, 1'b1, 20'h0FFFF);
      issue(1'b0, 2'd0, 16'h0100);
      check("R7 user limit write ignored", 1'b0, 1'b1, '0);
      write_cfg(1'b0, 2'd0, 1'b0, 20'h00000);
      issue(1'b0, 2'd0, 16'h0010);
      check("R7 user base write ignored", 1'b1, 1'b0, 20'h10010);

      // R6 write to absent segment has no effect
      write_cfg(1'b1, 2'd3, 1'b1, 20'h0FFFF);
      issue(1'b0, 2'd3, 16'h0001);
      check("R6 absent segment write", 1'b0, 1'b1, '0);

      // R8 same-cycle write and request
      cfg_we = 1; cfg_kernel = 1; cfg_seg = 2'd0; cfg_field = 1; cfg_data = 20'h00200;
      req_valid = 1; req_kernel = 0; req_seg = 2'd0; req_ofs = 16'h0150;
      @(negedge clk);
      cfg_we = 0;
      check("R8 old limit governs", 1'b0, 1'b1, '0);
      @(negedge clk);
      req_valid = 0;
      check("R6 new limit next cycle", 1'b1, 1'b0, 20'h10150);
      @(negedge clk);
      check("R9 idle after burst", 1'b0, 1'b0, '0);

      // R1 reset clears table again
      rst_n = 0;
      @(negedge clk);
      rst_n = 1;
      issue(1'b0, 2'd0, 16'h0000);
      check("R1 table cleared by reset", 1'b0, 1'b1, '0);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: run hung, actual=timeout expected=completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule